// File: doc/BRIEF.md
# One-Time-Programmable Patch Chain Decoder

This block rebuilds a fixed-layout logical map from a one-time-programmable array. Fuse bits can only go from 0 to 1, so the array does not hold a flat image. It holds a chain of small patch entries. Each entry starts with a one-byte header that names a logical section and says which 16-bit words of that section follow. When a value needs correcting, the fix is appended as a new entry further down the chain. Because entries are applied in order, the later entry wins.

A start pulse clears the logical map to all-ones. The decoder then reads the array one byte at a time through a synchronous read port, decodes each header, and writes the words that are present into the map. The walk stops at an unprogrammed header byte or at the end of the array. An entry that runs past the last byte stops the walk with an error flag, and the map keeps whatever was written before that entry. Other logic reads the map through a combinational read port.

Top module: `otp_map_walker`

## Requirements
- R1: A start pulse clears `done` and `err`, sets `busy` in the next cycle and presets every map byte to 0xFF in that same cycle.
- R2: A header byte splits in two. Bits 7:4 select a section of 8 map bytes, so the section base is index*8. Bits 3:0 are a word mask in which bit k = 0 means word k is present. Present words follow the header in ascending k.
- R3: Each present word takes two array bytes, low byte first. They are written to map bytes index*8+2k and index*8+2k+1.
- R4: A header byte of 0xFF ends the walk: `done` rises, `err` stays low and `busy` falls.
- R5: When two entries write the same map byte, the map ends up holding the value from the entry later in the chain.
- R6: Map bytes that no entry marks as present keep 0xFF after the walk.
- R7: If an entry's data would extend past the last array address, the walk ends with both `err` and `done` high. None of that entry's bytes are written, and all earlier writes are kept.
- R8: If the chain fills the array exactly and has no end marker, the walk ends at the last address with `done` high and `err` low.
- R9: `done` and `err` hold their values until the next start. A start that arrives during a walk abandons it and begins a new walk from address 0 with the map preset again.
- R10: The array is read only while `busy` is high. Each read returns its byte one cycle later, and every address presented is below the array size.
- R11: A header whose mask is 0xF (other than 0xFF) carries no data. The walk continues with the next byte as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins or restarts a walk |
| otp_rd | output | 1 | Read strobe to the array |
| otp_addr | output | AW | Array byte address |
| otp_data | input | 8 | Array byte, valid the cycle after `otp_rd` |
| map_raddr | input | 7 | Logical map byte address |
| map_rdata | output | 8 | Logical map byte, combinational from `map_raddr` |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished, held until the next start |
| err | output | 1 | Walk ended on an entry that overruns the array |

## Verification
A restart can land in the same cycle as a map byte write from the walk already in progress. When that happens, the preset and the restart must win over the pending write. The bench provokes this by loading a long chain and starting a walk. It then swaps the array for a short chain and pulses start again a dozen cycles later, in the middle of the data writes. It reads a byte the first walk had already written and expects 0xFF the cycle after the restart. It then expects the final map to match the short chain alone, with every byte written only by the abandoned walk back at 0xFF.

// File: rtl/otp_map_walker.sv
module otp_map_walker #(
  parameter int OTP_BYTES = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  output logic                         otp_rd,
  output logic [$clog2(OTP_BYTES)-1:0] otp_addr,
  input  logic [7:0]                   otp_data,
  input  logic [6:0]                   map_raddr,
  output logic [7:0]                   map_rdata,
  output logic                         busy,
  output logic                         done,
  output logic                         err
);
  localparam int AW        = $clog2(OTP_BYTES);
  localparam int MAP_BYTES = 128;
  localparam int PW        = AW + 2;
  localparam logic [PW-1:0] LAST = PW'(OTP_BYTES - 1);
  localparam logic [PW-1:0] SIZE = PW'(OTP_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_HDRD, S_DAT, S_DATD, S_FIN} state_t;

  state_t        state;
  logic [PW-1:0] ptr;
  logic [3:0]    sect, mask;
  logic [1:0]    widx;
  logic          phase;
  logic [7:0]    map [MAP_BYTES];

  function automatic logic [1:0] low_bit(input logic [3:0] m);
    if (m[0])      return 2'd0;
    else if (m[1]) return 2'd1;
    else if (m[2]) return 2'd2;
    else           return 2'd3;
  endfunction

  logic [3:0]    hdr_mask;
  logic [PW-1:0] hdr_end;
  logic [3:0]    rest;

  assign hdr_mask  = ~otp_data[3:0];
  assign hdr_end   = ptr + PW'({$countones(hdr_mask), 1'b0});
  assign rest      = mask & ~(4'b1 << widx);
  assign otp_rd    = ((state == S_HDR) && (ptr < SIZE)) || (state == S_DAT);
  assign otp_addr  = ptr[AW-1:0];
  assign busy      = (state != S_IDLE) && (state != S_FIN);
  assign map_rdata = map[map_raddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ptr   <= '0;
      sect  <= '0;
      mask  <= '0;
      widx  <= '0;
      phase <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else if (start) begin
      state <= S_HDR;
      ptr   <= '0;
      phase <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      case (state)
        S_HDR: begin
          if (ptr < SIZE) state <= S_HDRD;
          else begin
            state <= S_FIN;
            done  <= 1'b1;
          end
        end
        S_HDRD: begin
          if (otp_data == 8'hFF) begin
            state <= S_FIN;
            done  <= 1'b1;
          end else if (hdr_end > LAST) begin
            state <= S_FIN;
            done  <= 1'b1;
            err   <= 1'b1;
          end else begin
            ptr   <= ptr + 1'b1;
            sect  <= otp_data[7:4];
            mask  <= hdr_mask;
            widx  <= low_bit(hdr_mask);
            phase <= 1'b0;
            state <= (hdr_mask == 4'h0) ? S_HDR : S_DAT;
          end
        end
        S_DAT: state <= S_DATD;
        S_DATD: begin
          ptr <= ptr + 1'b1;
          if (!phase) begin
            phase <= 1'b1;
            state <= S_DAT;
          end else begin
            phase <= 1'b0;
            mask  <= rest;
            if (rest != 4'h0) begin
              widx  <= low_bit(rest);
              state <= S_DAT;
            end else begin
              state <= S_HDR;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      for (int i = 0; i < MAP_BYTES; i++) map[i] <= 8'hFF;
    end else if (state == S_DATD) begin
      map[{sect, widx, phase}] <= otp_data;
    end
  end
endmodule

module otp_map_walker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       otp_rd,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [7:0] map_rdata
);
  p_err_means_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, done}));
  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(err));
  p_start_preset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !done && !err && map_rdata == 8'hFF));
  p_read_while_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    otp_rd |-> busy);
endmodule

bind otp_map_walker otp_map_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .otp_rd(otp_rd),
  .busy(busy), .done(done), .err(err), .map_rdata(map_rdata)
);

// File: tb/otp_map_walker_bench.sv
module otp_map_walker_bench;
  localparam int N  = 64;
  localparam int AW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          otp_rd;
  logic [AW-1:0] otp_addr;
  logic [7:0]    otp_data;
  logic [6:0]    map_raddr = '0;
  logic [7:0]    map_rdata;
  logic          busy, done, err;

  logic [7:0] mem [N];
  logic [7:0] exp_map [128];
  logic       exp_err;
  int         n_chk = 0, n_bad = 0, rd_bad = 0;

  always #10 clk = ~clk;

  otp_map_walker #(.OTP_BYTES(N)) u_otp_map_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .otp_rd(otp_rd), .otp_addr(otp_addr),
    .otp_data(otp_data), .map_raddr(map_raddr), .map_rdata(map_rdata),
    .busy(busy), .done(done), .err(err)
  );

  always_ff @(posedge clk) if (otp_rd) otp_data <= mem[otp_addr];
  always @(posedge clk) if (rst_n && otp_rd && !busy) rd_bad++;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic blank();
    for (int i = 0; i < N; i++) mem[i] = 8'hFF;
  endtask

  task automatic model();
    int p;
    logic [7:0] h;
    for (int i = 0; i < 128; i++) exp_map[i] = 8'hFF;
    exp_err = 1'b0;
    p = 0;
    while (p < N) begin
      h = mem[p];
      if (h == 8'hFF) break;
      if (p + 2 * $countones(~h[3:0]) > N - 1) begin
        exp_err = 1'b1;
        break;
      end
      p++;
      for (int w = 0; w < 4; w++) begin
        if (!h[w]) begin
          exp_map[h[7:4] * 8 + w * 2]     = mem[p];
          exp_map[h[7:4] * 8 + w * 2 + 1] = mem[p + 1];
          p += 2;
        end
      end
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int t = 0;
    while (!done && t < 2000) begin
      @(negedge clk);
      t++;
    end
    check(done, {tag, " done"}, done, 1);
  endtask

  task automatic compare(input string tag);
    int bad = 0;
    model();
    check(err == exp_err, {tag, " err"}, err, exp_err);
    check(!busy, {tag, " busy low"}, busy, 0);
    for (int i = 0; i < 128; i++) begin
      map_raddr = 7'(i);
      #1;
      if (map_rdata !== exp_map[i]) begin
        bad++;
        $display("FAIL %s map[%0d] actual=%0h expected=%0h", tag, i, map_rdata, exp_map[i]);
      end
    end
    n_chk++;
    if (bad != 0) n_bad++;
  endtask

  task automatic run(input string tag);
    pulse_start();
    wait_done(tag);
    compare(tag);
  endtask

  task automatic t_reset();
    check(!done && !err && !busy, "R1 reset state", {done, err, busy}, 0);
  endtask

  task automatic t_basic();
    blank();
    mem[0] = 8'h3C; mem[1] = 8'h11; mem[2] = 8'h22; mem[3] = 8'h33; mem[4] = 8'h44;
    run("R2 R3 R4 basic entry");
  endtask

  task automatic t_override();
    blank();
    mem[0] = 8'h50; for (int i = 1; i <= 8; i++) mem[i] = 8'(8'h10 + i);
    mem[9] = 8'h5D; mem[10] = 8'hA1; mem[11] = 8'hA2;
    mem[12] = 8'h57; mem[13] = 8'hB1; mem[14] = 8'hB2;
    run("R5 R6 override");
  endtask

  task automatic t_sparse();
    blank();
    mem[0] = 8'h2F; mem[1] = 8'h7A; mem[2] = 8'hC3; mem[3] = 8'hD4;
    mem[4] = 8'hEF; mem[5] = 8'hF6; mem[6] = 8'h01; mem[7] = 8'h02; mem[8] = 8'h03; mem[9] = 8'h04;
    run("R11 R2 empty and sparse masks");
  endtask

  task automatic t_overrun();
    blank();
    mem[0] = 8'h1E; mem[1] = 8'h55; mem[2] = 8'h66;
    for (int i = 3; i < N; i += 3) begin
      if (i + 2 < N - 2) begin
        mem[i] = 8'h4E; mem[i+1] = 8'(i); mem[i+2] = 8'(i + 1);
      end
    end
    mem[60] = 8'h60; mem[61] = 8'h99; mem[62] = 8'h98; mem[63] = 8'h97;
    run("R7 overrun");
  endtask

  task automatic t_fill();
    blank();
    for (int e = 0; e < 7; e++) begin
      mem[e*9] = {4'(e), 4'h0};
      for (int b = 1; b < 9; b++) mem[e*9+b] = 8'(e * 16 + b);
    end
    mem[63] = 8'hBF;
    run("R8 exact fill");
  endtask

  task automatic t_blank();
    blank();
    run("R4 R6 blank array");
  endtask

  task automatic t_restart();
    blank();
    for (int e = 0; e < 7; e++) begin
      mem[e*9] = {4'(e + 8), 4'h0};
      for (int b = 1; b < 9; b++) mem[e*9+b] = 8'(8'h80 + e * 8 + b);
    end
    pulse_start();
    repeat (12) @(negedge clk);
    check(busy, "R9 first walk busy", busy, 1);
    blank();
    mem[0] = 8'h9C; mem[1] = 8'h5A; mem[2] = 8'hA5; mem[3] = 8'h3C; mem[4] = 8'hC3;
    map_raddr = 7'd64;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(map_rdata == 8'hFF, "R1 preset on restart", map_rdata, 8'hFF);
    check(busy && !done, "R1 R9 busy after restart", {busy, done}, 2'b10);
    wait_done("R9 restart");
    compare("R9 restart");
    repeat (5) @(negedge clk);
    check(done && !err, "R9 done held", {done, err}, 2'b10);
  endtask

  initial begin
    blank();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_override();
    t_sparse();
    t_overrun();
    t_fill();
    t_blank();
    t_restart();
    check(rd_bad == 0, "R10 reads only while busy", rd_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule